// File: doc/BRIEF.md
# Self-Synchronizing Flux Byte Sequencer

This block rebuilds bytes from the pulse stream of a floppy read head. Each cycle of a fixed sequencer clock it samples a one-bit pulse input. A pulse marks a flux transition and stands for a one bit; a cell with no pulse stands for a zero. A 16-state control table looks at the current state, the top bit of an 8-bit shift register and the pulse input. From these it picks the next state and one register command: hold, shift in 0, shift in 1, or clear.

Every valid byte on the medium has its top bit set. That bit therefore acts as the data-ready flag. The register needs no start marker to frame a byte: it is full when its top bit turns to 1. Once it is full, further zero cells are ignored, and the finished byte stays visible until the next byte has delivered its first two cells. Pulses that ring on after a transition are masked. Runs of all-ones bytes separated by one or two zero cells are enough to bring the sequencer into byte alignment.

Top module: `flux_byte_seq`

## Requirements
- R1: While `rst` is high, the sequencer returns to state 0 and the register is cleared, so `data_o` = 0x00 and `ready_o` = 0.
- R2: Shift commands move the register left by one and insert 0 or 1 at bit 0. Clear zeroes the register. When a held byte is dropped, `data_o` reads 0x00 for exactly one cycle and then 0x01.
- R3: With no pulses after reset, the sequencer shifts in a 1 and then a 0 every 8 cycles. `ready_o` first reads 1 after the 58th rising edge following reset release, with `data_o` = 0x80.
- R4: Once `ready_o` rises, `data_o` stays unchanged for at least 8 cycles. It also stays unchanged for as long as no pulse arrives.
- R5: A stream of 0xFF bytes, each followed by two zero cells, with 8-cycle cells and 1-cycle pulses, gives exactly one capture of 0xFF per byte sent.
- R6: The same holds when each 0xFF byte is followed by a single zero cell.
- R7: Back-to-back bytes with no gap are captured in order and with the correct value, given 8-cycle cells, top bit set and no more than two zero bits in a row.
- R8: R7 still holds when cell lengths repeat the pattern 8, 9, 7 cycles.
- R9: R7 still holds when every pulse is 2 cycles wide (ringing). In the mask state with the top bit clear, the sequencer stays put while the pulse input stays high.
- R10: `ready_o` falls only through a clear command, so on the first cycle it reads 0, `data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_pulse | input | 1 | Flux-transition pulse, sampled each cycle |
| data_o | output | DATA_W | Shift register contents |
| ready_o | output | 1 | Top bit of the register; high while a complete byte is held |

## Verification
The hold of a finished byte and the framing of the next byte overlap in time. The leading pulses of a new byte arrive while the old byte must still be readable, and the clear that ends the hold happens in the same cycle the new framing takes its first step. The bench provokes this overlap by sending bytes with no gap at all, with cells shortened to 7 cycles and with pulses widened by ringing. It judges the result by three things. The held value must stay stable for at least 8 cycles after each rise of `ready_o`. Each fall of `ready_o` must show 0x00 and then 0x01. The captured byte sequence must match the sent bytes exactly.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   typedef enum logic [1:0] {
      CMD_HOLD = 2'd0,
      CMD_SH0  = 2'd1,
      CMD_SH1  = 2'd2,
      CMD_CLR  = 2'd3
   } seq_cmd_t;

   localparam int unsigned STATE_W = 4;
   typedef logic [STATE_W-1:0] seq_state_t;

   // Named states whose codes the table and checks rely on
   localparam seq_state_t ST_ENTRY = 4'h0;
   localparam seq_state_t ST_FIRST = 4'h1;
   localparam seq_state_t ST_PARK  = 4'h2;
   localparam seq_state_t ST_WAIT3 = 4'h3;
   localparam seq_state_t ST_WAIT4 = 4'h4;
   localparam seq_state_t ST_WAIT8 = 4'h8;
   localparam seq_state_t ST_TIMEO = 4'h9;
   localparam seq_state_t ST_LEADA = 4'hA;
   localparam seq_state_t ST_LEADB = 4'hB;
   localparam seq_state_t ST_LEADC = 4'hC;
   localparam seq_state_t ST_MASK  = 4'hD;
   localparam seq_state_t ST_RELDE = 4'hE;
   localparam seq_state_t ST_RELDF = 4'hF;

endpackage

// File: rtl/fbs_table.sv
module fbs_table
   import fbs_pkg::*;
(
   input  seq_state_t state_i,
   input  logic       top_i,
   input  logic       pulse_i,
   output seq_cmd_t   cmd_o,
   output seq_state_t next_o
);

   always_comb begin
      cmd_o  = CMD_HOLD;
      next_o = state_i;
      case (state_i)
         ST_ENTRY: next_o = ST_FIRST;
         ST_FIRST: begin
            if (!top_i) begin
               cmd_o  = CMD_SH1;
               next_o = ST_PARK;
            end else begin
               next_o = ST_WAIT3;
            end
         end
         ST_PARK: begin
            if (top_i) next_o = pulse_i ? ST_ENTRY : ST_PARK;
            else       next_o = pulse_i ? ST_MASK  : ST_WAIT3;
         end
         ST_WAIT3: next_o = (pulse_i && !top_i) ? ST_MASK : ST_WAIT4;
         4'h4, 4'h5, 4'h6, 4'h7, ST_WAIT8:
            next_o = pulse_i ? ST_MASK : state_i + 4'd1;
         ST_TIMEO: begin
            if (pulse_i) begin
               next_o = ST_MASK;
            end else if (!top_i) begin
               cmd_o  = CMD_SH0;
               next_o = ST_PARK;
            end else begin
               next_o = ST_LEADA;
            end
         end
         ST_LEADA: begin
            if (!top_i) begin
               cmd_o  = CMD_SH1;
               next_o = pulse_i ? ST_LEADC : ST_LEADB;
            end else begin
               next_o = pulse_i ? ST_MASK : ST_LEADB;
            end
         end
         ST_LEADB: begin
            if (!top_i) begin
               cmd_o  = CMD_SH0;
               next_o = pulse_i ? ST_MASK : 4'h5;
            end else begin
               next_o = pulse_i ? ST_MASK : ST_LEADC;
            end
         end
         ST_LEADC: begin
            if (!top_i) begin
               cmd_o  = CMD_SH0;
               next_o = ST_MASK;
            end else if (pulse_i) begin
               next_o = ST_MASK;
            end else begin
               cmd_o  = CMD_CLR;
               next_o = ST_LEADA;
            end
         end
         ST_MASK: begin
            if (top_i) next_o = ST_RELDE;
            else       next_o = pulse_i ? ST_MASK : ST_ENTRY;
         end
         ST_RELDE: begin
            if (!top_i) cmd_o = CMD_SH1;
            next_o = ST_RELDF;
         end
         ST_RELDF: begin
            if (!top_i) begin
               cmd_o  = CMD_SH1;
               next_o = pulse_i ? ST_MASK : ST_WAIT4;
            end else begin
               cmd_o  = CMD_CLR;
               next_o = ST_RELDE;
            end
         end
         default: begin
            cmd_o  = CMD_HOLD;
            next_o = ST_ENTRY;
         end
      endcase
   end

endmodule

// File: rtl/fbs_shreg.sv
module fbs_shreg
   import fbs_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  seq_cmd_t         cmd_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned TOP = WIDTH - 1;

   logic do_shift;
   assign do_shift = (cmd_i == CMD_SH0) || (cmd_i == CMD_SH1);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic din;
      logic bit_q;
      if (i == 0) begin : g_lsb
         assign din = (cmd_i == CMD_SH1);
      end else begin : g_mid
         assign din = q_o[i-1];
      end
      always_ff @(posedge clk) begin
         if (rst || cmd_i == CMD_CLR) bit_q <= 1'b0;
         else if (do_shift)           bit_q <= din;
      end
      assign q_o[i] = bit_q;
   end

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == CMD_CLR) |=> (q_o == '0));

   // R2
   shift_one_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == CMD_SH1) |=> (q_o[0] && q_o[TOP:1] == $past(q_o[TOP-1:0])));

   // R2
   shift_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_i == CMD_SH0) |=> (!q_o[0] && q_o[TOP:1] == $past(q_o[TOP-1:0])));

endmodule

// File: rtl/flux_byte_seq.sv
module flux_byte_seq
   import fbs_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_pulse,
   output logic [DATA_W-1:0] data_o,
   output logic              ready_o
);

   localparam int unsigned MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_width_bad
      $error("flux_byte_seq: DATA_W must be at least 2");
   end

   seq_state_t  state_q;
   seq_state_t  state_d;
   seq_cmd_t    cmd;
   logic [MSB:0] reg_q;

   fbs_table u_table (
      .state_i (state_q),
      .top_i   (reg_q[MSB]),
      .pulse_i (rd_pulse),
      .cmd_o   (cmd),
      .next_o  (state_d)
   );

   fbs_shreg #(.WIDTH(DATA_W)) u_shreg (
      .clk   (clk),
      .rst   (rst),
      .cmd_i (cmd),
      .q_o   (reg_q)
   );

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_ENTRY;
      else     state_q <= state_d;
   end

   assign data_o  = reg_q;
   assign ready_o = reg_q[MSB];

   // R4
   park_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_PARK && ready_o && !rd_pulse) |=> ($stable(data_o) && state_q == ST_PARK));

   // R9
   ring_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_MASK && !ready_o && rd_pulse) |=> (state_q == ST_MASK));

   // R10
   ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(ready_o) |-> ($past(cmd) == CMD_CLR));

   // R3
   entry_step_chk: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ENTRY) |=> (state_q == ST_FIRST && $stable(data_o)));

endmodule

// File: tb/flux_byte_seq_tb.sv
module flux_byte_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NDAT = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rd_pulse = 1'b0;
   logic [7:0] data_o;
   logic       ready_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [7:0] cap [0:511];
   int ncap = 0;
   logic [7:0] dat [NDAT];

   bit mon_en = 0;
   bit prev_rdy = 0;
   bit post_fall = 0;
   int hold_left = 0;
   logic [7:0] held = '0;

   int pw = 1;
   bit jit_on = 0;
   int jit_idx = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flux_byte_seq #(.DATA_W(8)) u_dut (
      .clk      (clk),
      .rst      (rst),
      .rd_pulse (rd_pulse),
      .data_o   (data_o),
      .ready_o  (ready_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Capture monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (mon_en) begin
         if (post_fall) begin
            check(data_o == 8'h01, "R2", data_o, 8'h01);
            post_fall = 0;
         end
         if (ready_o && !prev_rdy) begin
            if (ncap < 512) cap[ncap] = data_o;
            ncap++;
            hold_left = 8;
            held = data_o;
         end else if (hold_left > 0) begin
            check(data_o == held, "R4", data_o, held);
            hold_left--;
         end
         if (!ready_o && prev_rdy) begin
            check(data_o == 8'h00, "R10", data_o, 8'h00);
            post_fall = 1;
         end
         prev_rdy = ready_o;
      end
   end

   function automatic int next_len();
      int l;
      if (!jit_on) return 8;
      case (jit_idx % 3)
         0: l = 8;
         1: l = 9;
         default: l = 7;
      endcase
      jit_idx++;
      return l;
   endfunction

   task automatic send_cell(input bit one);
      int len;
      len = next_len();
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rd_pulse = one && (i < pw);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input int gaps);
      for (int k = 7; k >= 0; k--) send_cell(b[k]);
      for (int g = 0; g < gaps; g++) send_cell(1'b0);
   endtask

   task automatic run_data(input string req);
      int base;
      for (int i = 0; i < 6; i++) send_byte(8'hFF, 2);
      base = ncap;
      for (int i = 0; i < NDAT; i++) send_byte(dat[i], 0);
      send_byte(8'hFF, 2);
      check(ncap - base == NDAT + 1, req, ncap - base, NDAT + 1);
      for (int i = 0; i < NDAT; i++)
         check(cap[base+i] == dat[i], req, cap[base+i], dat[i]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int base;
      dat[0] = 8'hD5; dat[1] = 8'hAA; dat[2] = 8'h96; dat[3] = 8'hAD;
      dat[4] = 8'hDE; dat[5] = 8'hEB; dat[6] = 8'h97; dat[7] = 8'hB5;
      dat[8] = 8'hF3; dat[9] = 8'hFF;

      // R1: reset state
      repeat (4) @(negedge clk);
      check(data_o == 8'h00, "R1", data_o, 8'h00);
      check(ready_o == 1'b0, "R1", ready_o, 0);
      rst = 1'b0;
      mon_en = 1;

      // R3: idle line produces 0x80 on edge 58
      repeat (57) @(negedge clk);
      check(ready_o == 1'b0, "R3", ready_o, 0);
      @(negedge clk);
      check(ready_o == 1'b1, "R3", ready_o, 1);
      check(data_o == 8'h80, "R3", data_o, 8'h80);
      repeat (100) @(negedge clk);
      check(data_o == 8'h80, "R4", data_o, 8'h80);

      // R5: two-zero gaps
      for (int i = 0; i < 8; i++) send_byte(8'hFF, 2);
      base = ncap;
      for (int i = 0; i < 4; i++) send_byte(8'hFF, 2);
      check(ncap - base == 4, "R5", ncap - base, 4);
      for (int i = 0; i < 4; i++) check(cap[base+i] == 8'hFF, "R5", cap[base+i], 8'hFF);

      // R6: one-zero gaps
      for (int i = 0; i < 6; i++) send_byte(8'hFF, 1);
      base = ncap;
      for (int i = 0; i < 4; i++) send_byte(8'hFF, 1);
      check(ncap - base == 4, "R6", ncap - base, 4);
      for (int i = 0; i < 4; i++) check(cap[base+i] == 8'hFF, "R6", cap[base+i], 8'hFF);

      // R7: back-to-back data, nominal cells
      run_data("R7");

      // R8: cell length variation
      jit_on = 1;
      jit_idx = 0;
      run_data("R8");
      jit_on = 0;

      // R9: ringing pulses two cycles wide
      pw = 2;
      run_data("R9");
      pw = 1;

      repeat (20) @(negedge clk);
      finish_run();
   end

endmodule